// File: doc/BRIEF.md
# Audio Frame Sequencer with Parity-Aligned Restart

This block is the timing backbone of a CPU-clocked audio unit. It counts CPU cycles and emits two kinds of single-cycle strobe, a quarter-frame tick and a half-frame tick, which the sound channels use to advance their envelopes, sweeps and length counters. In the four-step sequence it also raises a level-sensitive frame interrupt once per frame. Software programs it through one control byte and polls it through a status read that returns the interrupt flag and clears it.

A control write does not restart the count at once. A free-running toggle splits cycles into even (toggle 0) and odd (toggle 1). The restart is held back until the first even cycle that is at least two cycles past the write. A write therefore moves every later strobe and interrupt by a delay that depends on the parity of the cycle in which it was made. The sequence length is set by the parameter `STEP_CYCLES` (S, default 7457).

Top module: `frame_sequencer`

## Requirements
- R1: After synchronous reset the strobes and `irq` are low, the sequence is four-step with the interrupt allowed, the parity toggle is even in the first cycle after reset and the counter runs from zero.
- R2: A write on `ctrl_we` takes bit 7 of `ctrl_wdata` as the sequence select (1 = five-step) and bit 6 as interrupt inhibit; the other six bits have no effect.
- R3: The counter restart after a write lands in the second cycle after a write made on an even cycle and in the third cycle after a write made on an odd cycle; a newer write cancels a pending restart.
- R4: When the five-step sequence is selected, `qtr_stb` and `half_stb` pulse together in the cycle after the restart lands (3 cycles after an even write, 4 after an odd one).
- R5: In both sequences `qtr_stb` pulses S+3, 2S+3, 3S+3 and 4S+3 cycles after the restart lands, and `half_stb` pulses only with the second and fourth of these.
- R6: With the defaults, a write of 0x00 raises `irq` 29833 cycles after an even write and 29834 cycles after an odd write (4S+5 and 4S+6).
- R7: Without further writes the four-step sequence repeats every 4S+2 cycles, so the interrupt flag sets again 29830 cycles after its previous setting point.
- R8: The five-step sequence has a fifth step that emits no strobe, repeats every 5S+2 cycles and never sets the interrupt flag.
- R9: A write with the inhibit bit set drops `irq` in the next cycle, and while inhibit is set the flag cannot set.
- R10: During a cycle with `stat_re` high, `stat_irq` shows the flag; the flag is low the next cycle unless a set event falls in the same cycle.
- R11: `irq` is a level that stays high until a status read or an inhibit write clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte: bit 7 five-step select, bit 6 interrupt inhibit |
| stat_re | input | 1 | Status read strobe |
| stat_irq | output | 1 | Interrupt flag as returned by a status read |
| qtr_stb | output | 1 | Quarter-frame strobe |
| half_stb | output | 1 | Half-frame strobe |
| irq | output | 1 | Frame interrupt, level |

## Verification
A wrong parity toggle or a pending-restart stage that is off by one shows up as the landing strobe of a five-step write arriving one cycle early or late, seen within four cycles of the write, and as a frame interrupt one cycle off from 29833/29834. A counter that wraps at the wrong value only shows at the next frame boundary, about 29830 cycles later, as a shifted interrupt rise or an extra or missing quarter strobe in a counted window. A flag with the wrong clear priority shows in the cycle after a status read or an inhibit write; a reference model run in lock-step flags any of these on the cycle they occur.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    localparam int CTRL_W   = 8;
    localparam int MODE_BIT = 7;
    localparam int INH_BIT  = 6;
    localparam int unsigned STEPS_FOUR = 4;
    localparam int unsigned STEPS_FIVE = 5;

    typedef enum logic {
        SEQ_FOUR = 1'b0,
        SEQ_FIVE = 1'b1
    } seq_mode_e;

    typedef struct packed {
        seq_mode_e mode;
        logic      inhibit;
    } ctrl_t;

    typedef struct packed {
        logic qtr;
        logic half;
        logic frame;
    } step_evt_t;

    function automatic ctrl_t decode_ctrl(input logic [CTRL_W-1:0] d);
        ctrl_t c;
        c.mode    = d[MODE_BIT] ? SEQ_FIVE : SEQ_FOUR;
        c.inhibit = d[INH_BIT];
        return c;
    endfunction

    // Counter value at which step k fires.
    function automatic int unsigned step_mark(input int unsigned step_len,
                                              input int unsigned k);
        return step_len * k + 32'd1;
    endfunction

    // Last counter value of a frame before it wraps to zero.
    function automatic int unsigned frame_last(input int unsigned step_len,
                                               input seq_mode_e m);
        return (m == SEQ_FIVE) ? step_mark(step_len, STEPS_FIVE)
                               : step_mark(step_len, STEPS_FOUR);
    endfunction

    function automatic step_evt_t step_event(input int unsigned cnt,
                                             input int unsigned step_len,
                                             input seq_mode_e m);
        step_evt_t e;
        e = '0;
        for (int unsigned k = 1; k <= STEPS_FOUR; k++) begin
            if (cnt == step_mark(step_len, k)) begin
                e.qtr = 1'b1;
                if (k % 2 == 0) e.half = 1'b1;
                if (k == STEPS_FOUR && m == SEQ_FOUR) e.frame = 1'b1;
            end
        end
        return e;
    endfunction

endpackage

// File: rtl/fseq_restart.sv
module fseq_restart (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    output logic land
);
    logic ph_q;
    logic armed_q;
    logic ready_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q    <= 1'b0;
            armed_q <= 1'b0;
            ready_q <= 1'b0;
        end else begin
            ph_q    <= ~ph_q;
            armed_q <= wr_en;
            if (wr_en)        ready_q <= 1'b0;
            else if (armed_q) ready_q <= 1'b1;
            else if (land)    ready_q <= 1'b0;
        end
    end

    assign land = ready_q & ~ph_q;

    // R3: a restart always traces back to a write two or three cycles earlier
    a_r3_land_after_write: assert property (@(posedge clk) disable iff (rst)
        land |-> ($past(wr_en, 2) || $past(wr_en, 3)));

    // R3: never lands in the cycle right after a write
    a_r3_no_early_land: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !land);

endmodule

// File: rtl/fseq_counter.sv
module fseq_counter
    import fseq_pkg::*;
#(
    parameter int unsigned STEP_CYCLES = 7457,
    parameter int          CNT_W       = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      land,
    input  seq_mode_e mode,
    output step_evt_t evt
);
    logic [CNT_W-1:0] cnt_q;
    int unsigned      last;

    always_comb last = frame_last(STEP_CYCLES, mode);

    always_ff @(posedge clk) begin
        if (rst || land)               cnt_q <= '0;
        else if (32'(cnt_q) >= last)   cnt_q <= '0;
        else                           cnt_q <= cnt_q + 1'b1;
    end

    assign evt = land ? '0 : step_event(32'(cnt_q), STEP_CYCLES, mode);

    // R8: the count never runs past the longest frame
    a_r8_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
        32'(cnt_q) <= frame_last(STEP_CYCLES, SEQ_FIVE));

endmodule

// File: rtl/fseq_irq.sv
module fseq_irq (
    input  logic clk,
    input  logic rst,
    input  logic clr_now,
    input  logic inhibit_q,
    input  logic set_evt,
    input  logic rd_en,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)                          flag <= 1'b0;
        else if (clr_now)                 flag <= 1'b0;
        else if (set_evt && !inhibit_q)   flag <= 1'b1;
        else if (rd_en)                   flag <= 1'b0;
    end

    a_r9_inhibit_clears: assert property (@(posedge clk) disable iff (rst)
        clr_now |=> !flag);

    a_r9_inhibit_blocks: assert property (@(posedge clk) disable iff (rst)
        (inhibit_q && !flag) |=> !flag);

    a_r10_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_en && flag && !set_evt) |=> !flag);

    a_r11_level_hold: assert property (@(posedge clk) disable iff (rst)
        (flag && !rd_en && !clr_now) |=> flag);

endmodule

// File: rtl/frame_sequencer.sv
module frame_sequencer
    import fseq_pkg::*;
#(
    parameter int unsigned STEP_CYCLES = 7457
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              stat_re,
    output logic              stat_irq,
    output logic              qtr_stb,
    output logic              half_stb,
    output logic              irq
);
    localparam int CNT_W = $clog2(STEPS_FIVE * STEP_CYCLES + 2);

    ctrl_t     ctrl_q;
    ctrl_t     ctrl_new;
    logic      land;
    step_evt_t evt;
    logic      qtr_q;
    logic      half_q;
    logic      flag;

    always_comb ctrl_new = decode_ctrl(ctrl_wdata);

    always_ff @(posedge clk) begin
        if (rst)          ctrl_q <= '{mode: SEQ_FOUR, inhibit: 1'b0};
        else if (ctrl_we) ctrl_q <= ctrl_new;
    end

    fseq_restart u_restart (
        .clk   (clk),
        .rst   (rst),
        .wr_en (ctrl_we),
        .land  (land)
    );

    fseq_counter #(
        .STEP_CYCLES (STEP_CYCLES),
        .CNT_W       (CNT_W)
    ) u_counter (
        .clk  (clk),
        .rst  (rst),
        .land (land),
        .mode (ctrl_q.mode),
        .evt  (evt)
    );

    fseq_irq u_irq (
        .clk       (clk),
        .rst       (rst),
        .clr_now   (ctrl_we && ctrl_new.inhibit),
        .inhibit_q (ctrl_q.inhibit),
        .set_evt   (evt.frame),
        .rd_en     (stat_re),
        .flag      (flag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            qtr_q  <= 1'b0;
            half_q <= 1'b0;
        end else if (land) begin
            qtr_q  <= (ctrl_q.mode == SEQ_FIVE);
            half_q <= (ctrl_q.mode == SEQ_FIVE);
        end else begin
            qtr_q  <= evt.qtr;
            half_q <= evt.half;
        end
    end

    assign qtr_stb  = qtr_q;
    assign half_stb = half_q;
    assign irq      = flag;
    assign stat_irq = stat_re & flag;

    a_r5_half_with_qtr: assert property (@(posedge clk) disable iff (rst)
        half_stb |-> qtr_stb);

    a_r4_landing_strobes: assert property (@(posedge clk) disable iff (rst)
        (land && ctrl_q.mode == SEQ_FIVE) |=> (qtr_stb && half_stb));

    a_r8_five_no_irq: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.mode == SEQ_FIVE && !irq) |=> !irq);

endmodule

// File: tb/frame_sequencer_test.sv
module frame_sequencer_test;

    localparam int          CLK_PERIOD = 10;
    localparam int unsigned STEP       = 7457;
    localparam int          WATCHDOG   = 198000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       we  = 1'b0;
    logic [7:0] wd  = 8'h00;
    logic       re  = 1'b0;
    logic       stat_irq, qtr_stb, half_stb, irq;

    int  errors = 0;
    int  checks = 0;
    bit  cmp_on = 0;
    bit  done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    frame_sequencer #(.STEP_CYCLES(STEP)) uut (
        .clk        (clk),
        .rst        (rst),
        .ctrl_we    (we),
        .ctrl_wdata (wd),
        .stat_re    (re),
        .stat_irq   (stat_irq),
        .qtr_stb    (qtr_stb),
        .half_stb   (half_stb),
        .irq        (irq)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model built from the requirements
    int unsigned m_cnt;
    bit          m_ph, m_five, m_inh, m_flag, m_q, m_h;
    longint      m_cyc, m_land;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_ph = 0; m_five = 0; m_inh = 0; m_flag = 0;
            m_q = 0; m_h = 0; m_cyc = 0; m_land = -1;
        end else begin
            bit lnd, eq, eh, ei;
            int unsigned last;
            lnd = (m_cyc == m_land);
            eq = 0; eh = 0; ei = 0;
            if (!lnd) begin
                for (int unsigned k = 1; k <= 4; k++) begin
                    if (m_cnt == STEP * k + 1) begin
                        eq = 1;
                        if (k == 2 || k == 4) eh = 1;
                        if (k == 4 && !m_five) ei = 1;
                    end
                end
            end
            m_q = lnd ? m_five : eq;
            m_h = lnd ? m_five : eh;
            if (we && wd[6])          m_flag = 0;
            else if (ei && !m_inh)    m_flag = 1;
            else if (re)              m_flag = 0;
            last = m_five ? 5 * STEP + 1 : 4 * STEP + 1;
            if (lnd)                  m_cnt = 0;
            else if (m_cnt >= last)   m_cnt = 0;
            else                      m_cnt++;
            if (we) begin
                m_land = m_cyc + (m_ph ? 3 : 2);
                m_five = wd[7];
                m_inh  = wd[6];
            end
            m_ph = !m_ph;
            m_cyc++;
        end
    end

    always @(negedge clk) begin
        if (!rst && cmp_on && !done) begin
            check(qtr_stb == m_q,  "R2 R3 R4 R5 R8 model qtr_stb", int'(qtr_stb), int'(m_q));
            check(half_stb == m_h, "R2 R4 R5 R8 model half_stb", int'(half_stb), int'(m_h));
            check(irq == m_flag,   "R6 R7 R9 R10 R11 model irq", int'(irq), int'(m_flag));
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic write_ctrl(input logic [7:0] v);
        we = 1'b1; wd = v;
        tick();
        we = 1'b0; wd = 8'h00;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int qn, hn, in;
        void'($urandom(32'd20240611));
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1: reset state
        check(qtr_stb == 0, "R1 qtr_stb after reset", int'(qtr_stb), 0);
        check(half_stb == 0, "R1 half_stb after reset", int'(half_stb), 0);
        check(irq == 0, "R1 irq after reset", int'(irq), 0);
        re = 1'b1; #1;
        check(stat_irq == 0, "R1 stat_irq after reset", int'(stat_irq), 0);
        tick(); re = 1'b0;
        cmp_on = 1;

        // R6: even-cycle write of 0x00
        while (m_ph != 0) tick();
        write_ctrl(8'h00);
        repeat (29831) tick();
        check(irq == 0, "R6 even write irq one cycle early", int'(irq), 0);
        tick();
        check(irq == 1, "R6 even write irq at 29833", int'(irq), 1);

        // R10: status read returns flag and clears it
        re = 1'b1; #1;
        check(stat_irq == 1, "R10 stat_irq during read", int'(stat_irq), 1);
        tick(); re = 1'b0;
        check(irq == 0, "R10 irq after read", int'(irq), 0);

        // R6: odd-cycle write of 0x00
        while (m_ph != 1) tick();
        write_ctrl(8'h00);
        repeat (29832) tick();
        check(irq == 0, "R6 odd write irq one cycle early", int'(irq), 0);
        tick();
        check(irq == 1, "R6 odd write irq at 29834", int'(irq), 1);

        // R11: level holds with no read
        repeat (5) tick();
        check(irq == 1, "R11 irq held", int'(irq), 1);
        re = 1'b1;
        tick(); re = 1'b0;
        check(irq == 0, "R10 irq cleared by read", int'(irq), 0);

        // R7: next setting point one period after the first
        repeat (29823) tick();
        check(irq == 0, "R7 periodic irq one cycle early", int'(irq), 0);
        tick();
        check(irq == 1, "R7 periodic irq at 29830", int'(irq), 1);

        // R9: inhibit write clears and blocks; R5 strobe counts in four-step
        write_ctrl(8'h40);
        check(irq == 0, "R9 irq cleared by inhibit", int'(irq), 0);
        qn = 0; hn = 0; in = 0;
        repeat (29840) begin
            tick();
            qn += int'(qtr_stb); hn += int'(half_stb); in += int'(irq);
        end
        check(in == 0, "R9 irq blocked while inhibited", in, 0);
        check(qn == 4, "R5 quarter strobes per four-step frame", qn, 4);
        check(hn == 2, "R5 half strobes per four-step frame", hn, 2);

        // R3/R4: five-step write on an even cycle
        while (m_ph != 0) tick();
        write_ctrl(8'h80);
        check(qtr_stb == 0, "R3 even write no strobe at +1", int'(qtr_stb), 0);
        tick();
        check(qtr_stb == 0, "R3 even write no strobe at +2", int'(qtr_stb), 0);
        tick();
        check(qtr_stb == 1 && half_stb == 1, "R4 landing strobes at +3",
              int'({qtr_stb, half_stb}), 3);
        // R8: one full five-step frame
        qn = 1; hn = 1; in = 0;
        repeat (37300) begin
            tick();
            qn += int'(qtr_stb); hn += int'(half_stb); in += int'(irq);
        end
        check(qn == 5, "R8 quarter strobes incl. landing", qn, 5);
        check(hn == 3, "R8 half strobes incl. landing", hn, 3);
        check(in == 0, "R8 no irq in five-step", in, 0);

        // R3: five-step write on an odd cycle lands one cycle later
        while (m_ph != 1) tick();
        write_ctrl(8'h80);
        tick(); tick();
        check(qtr_stb == 0, "R3 odd write no strobe at +3", int'(qtr_stb), 0);
        tick();
        check(qtr_stb == 1, "R3 odd write strobe at +4", int'(qtr_stb), 1);

        // Random traffic, checked against the model (R2 other bits ignored)
        repeat (5000) begin
            we = (($urandom % 300) == 0);
            wd = 8'($urandom);
            re = (($urandom % 16) == 0);
            tick();
        end
        we = 1'b0; re = 1'b0;
        tick();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule